// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 128 level-sensitive interrupt lines and drives two processor request outputs. One is a normal request and the other is a fast request. Each line can be masked. Software can also force a line pending without touching the wire. Every line carries its own configuration word, which sets a priority and chooses which of the two outputs it belongs to.

For each output, the controller looks at the lines that are pending, unmasked, routed to that output and below the global threshold. It selects the most urgent of them. The number of the selected line is latched and the request output is raised. Both stay frozen until software writes the matching acknowledge strobe. Selection for that output starts again on the clock after the acknowledge.

All registers sit on a simple word-addressed register bus. Writes take effect on the clock edge. Read data is combinational from the current address.

Top module: `prio_intc`

## Requirements
- R1: After the reset input, both request outputs are low and every line is masked (each mask bank reads 0xFFFFFFFF). The threshold reads 0, both active-number registers read 0x80, and the status register reads 1.
- R2: Lines are grouped in four banks of 32. Line n sits in bank n>>5, bit n&31. Bank b has three word addresses:
  - mask readback at 0x010+b;
  - write-one-to-set mask at 0x014+b;
  - write-one-to-clear mask at 0x018+b.
  Zero bits written to the set and clear aliases change nothing. A masked line never produces a request.
- R3: Writing ones to 0x01C+b forces those lines of bank b pending. Writing ones to 0x020+b removes the forced state. Zero bits change nothing. Address 0x01C+b reads back the forced bits of bank b.
- R4: Line n has a configuration word at 0x100+n. Bit 0 set routes the line to the fast output; bit 0 clear routes it to the normal output. Bits 8:2 hold a 7-bit priority. The word reads back with all other bits zero.
- R5: Among the candidate lines of one output, the smallest priority value wins. On equal priority, the lowest line number wins.
- R6: The threshold register is at 0x003 (8 bits). A line is a candidate only if its priority is strictly below the threshold.
- R7: Once a line is selected, the request output stays high and the active number stays frozen until an acknowledge, even if the line drops. The acknowledge is a write to 0x002: bit 0 for the normal output, bit 1 for the fast output. The request is low in the cycle after the acknowledge edge. A still-pending line is selected on the following edge.
- R8: The active-number registers are at 0x004 (normal) and 0x005 (fast). While a request is held, the register reads the line number in bits 6:0 with bit 7 clear. With no request held, it reads 0x80 and the output is low.
- R9: Writing bit 0 of 0x000 returns all masks, forced bits, configuration words, the threshold and both held selections to their reset values at that edge. The status register at 0x001 reads 0 in the cycle that follows and 1 after that.
- R10: A line is pending when its hardware input is high or its forced bit is set. The hardware input is level-sensitive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Register write enable |
| busAddr | input | 9 | Register word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| srcIn | input | 128 | Level-sensitive interrupt lines |
| irqReq | output | 1 | Normal interrupt request |
| fiqReq | output | 1 | Fast interrupt request |

## Verification
A corrupted mask or forced-pending bit shows up as a request that appears or fails to appear one edge after the register write. It also shows on the bank readback on the very next read. A wrong tie-break or threshold comparison shows as the wrong line number in the active register. This is visible in the cycle right after the selection edge. A hold state that fails to clear or to freeze is visible at once on the request output in the cycle after an acknowledge. It also shows when the source line drops while a request is held.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  parameter int NUM_SRC = 128;
  parameter int BANK_W = 32;
  parameter int PRIO_W = 7;
  parameter int ADDR_W = 9;
  localparam int NUM_BANK = NUM_SRC / BANK_W;
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int BANK_SEL_W = $clog2(NUM_BANK);
  localparam int THR_W = PRIO_W + 1;
  localparam int NUM_ROUTE = 2;

  localparam logic [ADDR_W-1:0] A_SYSCFG  = 9'h000;
  localparam logic [ADDR_W-1:0] A_SYSSTAT = 9'h001;
  localparam logic [ADDR_W-1:0] A_CTRL    = 9'h002;
  localparam logic [ADDR_W-1:0] A_THRESH  = 9'h003;
  localparam logic [ADDR_W-1:0] A_IRQACT  = 9'h004;
  localparam logic [ADDR_W-1:0] A_FIQACT  = 9'h005;
  localparam logic [ADDR_W-1:0] A_MASK    = 9'h010;
  localparam logic [ADDR_W-1:0] A_MASKSET = 9'h014;
  localparam logic [ADDR_W-1:0] A_MASKCLR = 9'h018;
  localparam logic [ADDR_W-1:0] A_SWSET   = 9'h01C;
  localparam logic [ADDR_W-1:0] A_SWCLR   = 9'h020;
  localparam logic [ADDR_W-1:0] A_CFG     = 9'h100;

  localparam logic [ADDR_W-BANK_SEL_W-1:0] PG_MASK    = A_MASK[ADDR_W-1:BANK_SEL_W];
  localparam logic [ADDR_W-BANK_SEL_W-1:0] PG_MASKSET = A_MASKSET[ADDR_W-1:BANK_SEL_W];
  localparam logic [ADDR_W-BANK_SEL_W-1:0] PG_MASKCLR = A_MASKCLR[ADDR_W-1:BANK_SEL_W];
  localparam logic [ADDR_W-BANK_SEL_W-1:0] PG_SWSET   = A_SWSET[ADDR_W-1:BANK_SEL_W];
  localparam logic [ADDR_W-BANK_SEL_W-1:0] PG_SWCLR   = A_SWCLR[ADDR_W-1:BANK_SEL_W];
  localparam logic [ADDR_W-SRC_W-1:0]      PG_CFG     = A_CFG[ADDR_W-1:SRC_W];

  typedef struct packed {
    logic                  softRst;
    logic                  thrWe;
    logic                  maskSet;
    logic                  maskClr;
    logic                  swSet;
    logic                  swClr;
    logic                  cfgWe;
    logic [BANK_SEL_W-1:0] bank;
    logic [SRC_W-1:0]      cfgIdx;
    logic [BANK_W-1:0]     wdata;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_STAT, RD_THR, RD_ACT0, RD_ACT1, RD_MASK, RD_SW, RD_CFG
  } rdSel_e;
endpackage

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [THR_W-1:0]               thr,
  output logic                           found,
  output logic [SRC_W-1:0]               winNum
);
  logic [PRIO_W-1:0] bestPrio;

  always_comb begin
    found = 1'b0;
    bestPrio = '0;
    winNum = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && ({1'b0, prio[i]} < thr) && (!found || prio[i] < bestPrio)) begin
        found = 1'b1;
        bestPrio = prio[i];
        winNum = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc_core.sv
module prio_intc_core
  import prio_intc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic [NUM_SRC-1:0]    srcIn,
  output logic [NUM_ROUTE-1:0]  candValid,
  output logic [SRC_W-1:0]      candNum [NUM_ROUTE],
  output logic [BANK_W-1:0]     selMask,
  output logic [BANK_W-1:0]     selSw,
  output logic [BANK_W-1:0]     selCfg,
  output logic [THR_W-1:0]      thrVal,
  output logic                  busy,
  output logic [NUM_SRC-1:0]    maskAll
);
  logic [NUM_SRC-1:0]             maskQ;
  logic [NUM_SRC-1:0]             swQ;
  logic [NUM_SRC-1:0]             routeQ;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioQ;
  logic [THR_W-1:0]               thrQ;
  logic                           busyQ;
  logic [NUM_SRC-1:0]             pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      swQ    <= '0;
      routeQ <= '0;
      prioQ  <= '0;
      thrQ   <= '0;
      busyQ  <= 1'b0;
    end else if (st.softRst) begin
      maskQ  <= '1;
      swQ    <= '0;
      routeQ <= '0;
      prioQ  <= '0;
      thrQ   <= '0;
      busyQ  <= 1'b1;
    end else begin
      busyQ <= 1'b0;
      if (st.maskSet)
        maskQ[st.bank*BANK_W +: BANK_W] <= maskQ[st.bank*BANK_W +: BANK_W] | st.wdata;
      if (st.maskClr)
        maskQ[st.bank*BANK_W +: BANK_W] <= maskQ[st.bank*BANK_W +: BANK_W] & ~st.wdata;
      if (st.swSet)
        swQ[st.bank*BANK_W +: BANK_W] <= swQ[st.bank*BANK_W +: BANK_W] | st.wdata;
      if (st.swClr)
        swQ[st.bank*BANK_W +: BANK_W] <= swQ[st.bank*BANK_W +: BANK_W] & ~st.wdata;
      if (st.cfgWe) begin
        routeQ[st.cfgIdx] <= st.wdata[0];
        prioQ[st.cfgIdx]  <= st.wdata[PRIO_W+1:2];
      end
      if (st.thrWe)
        thrQ <= st.wdata[THR_W-1:0];
    end
  end

  assign pend = srcIn | swQ;

  for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_route
    logic [NUM_SRC-1:0] eligR;
    assign eligR = pend & ~maskQ & (r == 0 ? ~routeQ : routeQ);
    prio_intc_arb u_arb (
      .elig   (eligR),
      .prio   (prioQ),
      .thr    (thrQ),
      .found  (candValid[r]),
      .winNum (candNum[r])
    );
  end

  assign selMask = maskQ[st.bank*BANK_W +: BANK_W];
  assign selSw   = swQ[st.bank*BANK_W +: BANK_W];
  assign selCfg  = BANK_W'({prioQ[st.cfgIdx], 1'b0, routeQ[st.cfgIdx]});
  assign thrVal  = thrQ;
  assign busy    = busyQ;
  assign maskAll = maskQ;
endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BANK_W-1:0]    busWrData,
  output logic [BANK_W-1:0]    busRdData,
  output strobe_t              st,
  input  logic [NUM_ROUTE-1:0] candValid,
  input  logic [SRC_W-1:0]     candNum [NUM_ROUTE],
  input  logic [BANK_W-1:0]    selMask,
  input  logic [BANK_W-1:0]    selSw,
  input  logic [BANK_W-1:0]    selCfg,
  input  logic [THR_W-1:0]     thrVal,
  input  logic                 busy,
  output logic [NUM_ROUTE-1:0] heldOut,
  output logic [SRC_W-1:0]     actNum [NUM_ROUTE]
);
  logic [ADDR_W-BANK_SEL_W-1:0] bankPg;
  logic [ADDR_W-SRC_W-1:0]      cfgPg;
  logic [NUM_ROUTE-1:0]         ackWr;
  logic [NUM_ROUTE-1:0]         heldQ;
  logic [SRC_W-1:0]             numQ [NUM_ROUTE];
  rdSel_e                       rdSel;

  assign bankPg = busAddr[ADDR_W-1:BANK_SEL_W];
  assign cfgPg  = busAddr[ADDR_W-1:SRC_W];

  always_comb begin
    st = '0;
    st.bank   = busAddr[BANK_SEL_W-1:0];
    st.cfgIdx = busAddr[SRC_W-1:0];
    st.wdata  = busWrData;
    if (busWe) begin
      st.softRst = (busAddr == A_SYSCFG) && busWrData[0];
      st.thrWe   = (busAddr == A_THRESH);
      st.maskSet = (bankPg == PG_MASKSET);
      st.maskClr = (bankPg == PG_MASKCLR);
      st.swSet   = (bankPg == PG_SWSET);
      st.swClr   = (bankPg == PG_SWCLR);
      st.cfgWe   = (cfgPg == PG_CFG);
    end
  end

  assign ackWr = (busWe && busAddr == A_CTRL) ? busWrData[NUM_ROUTE-1:0] : '0;

  for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_hold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        heldQ[r] <= 1'b0;
        numQ[r]  <= '0;
      end else if (st.softRst || (heldQ[r] && ackWr[r])) begin
        heldQ[r] <= 1'b0;
      end else if (!heldQ[r] && candValid[r]) begin
        heldQ[r] <= 1'b1;
        numQ[r]  <= candNum[r];
      end
    end
    assign actNum[r] = numQ[r];
  end

  assign heldOut = heldQ;

  always_comb begin
    rdSel = RD_NONE;
    if (busAddr == A_SYSSTAT)       rdSel = RD_STAT;
    else if (busAddr == A_THRESH)   rdSel = RD_THR;
    else if (busAddr == A_IRQACT)   rdSel = RD_ACT0;
    else if (busAddr == A_FIQACT)   rdSel = RD_ACT1;
    else if (bankPg == PG_MASK)     rdSel = RD_MASK;
    else if (bankPg == PG_SWSET)    rdSel = RD_SW;
    else if (cfgPg == PG_CFG)       rdSel = RD_CFG;
  end

  always_comb begin
    busRdData = '0;
    case (rdSel)
      RD_STAT: busRdData = BANK_W'(!busy);
      RD_THR:  busRdData = BANK_W'(thrVal);
      RD_ACT0: busRdData = heldQ[0] ? BANK_W'(numQ[0]) : BANK_W'(1 << SRC_W);
      RD_ACT1: busRdData = heldQ[1] ? BANK_W'(numQ[1]) : BANK_W'(1 << SRC_W);
      RD_MASK: busRdData = selMask;
      RD_SW:   busRdData = selSw;
      RD_CFG:  busRdData = selCfg;
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BANK_W-1:0]  busWrData,
  output logic [BANK_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqReq,
  output logic               fiqReq
);
  strobe_t              st;
  logic [NUM_ROUTE-1:0] candValid;
  logic [SRC_W-1:0]     candNum [NUM_ROUTE];
  logic [BANK_W-1:0]    selMask, selSw, selCfg;
  logic [THR_W-1:0]     thrVal;
  logic                 busy;
  logic [NUM_SRC-1:0]   maskAll;
  logic [NUM_ROUTE-1:0] heldOut;
  logic [SRC_W-1:0]     actNum [NUM_ROUTE];

  prio_intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .st(st),
    .candValid(candValid), .candNum(candNum), .selMask(selMask),
    .selSw(selSw), .selCfg(selCfg), .thrVal(thrVal), .busy(busy),
    .heldOut(heldOut), .actNum(actNum)
  );

  prio_intc_core u_core (
    .clk(clk), .rstN(rstN), .st(st), .srcIn(srcIn),
    .candValid(candValid), .candNum(candNum), .selMask(selMask),
    .selSw(selSw), .selCfg(selCfg), .thrVal(thrVal), .busy(busy),
    .maskAll(maskAll)
  );

  assign irqReq = heldOut[0];
  assign fiqReq = heldOut[1];
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [BANK_W-1:0]  busWrData,
  input logic [BANK_W-1:0]  busRdData,
  input logic               irqReq,
  input logic               fiqReq,
  input logic [NUM_SRC-1:0] maskAll,
  input logic [SRC_W-1:0]   irqNum,
  input logic [SRC_W-1:0]   fiqNum
);
  logic               srWr, ackIrqWr, ackFiqWr;
  logic [NUM_SRC-1:0] maskPrev;

  assign srWr     = busWe && busAddr == A_SYSCFG && busWrData[0];
  assign ackIrqWr = busWe && busAddr == A_CTRL && busWrData[0];
  assign ackFiqWr = busWe && busAddr == A_CTRL && busWrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskPrev <= '1;
    else       maskPrev <= maskAll;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !ackIrqWr && !srWr |=> irqReq && $stable(irqNum)); // R7
  AST_FIQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq && !ackFiqWr && !srWr |=> fiqReq && $stable(fiqNum)); // R7
  AST_IRQ_ACK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && ackIrqWr |=> !irqReq); // R7
  AST_FIQ_ACK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq && ackFiqWr |=> !fiqReq); // R7
  AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq && busAddr == A_IRQACT |-> busRdData == 32'h80); // R8
  AST_SOFTRST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    srWr |=> (&maskAll) && !irqReq && !fiqReq); // R9
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> !maskPrev[irqNum]); // R2
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq),
  .fiqReq(fiqReq), .maskAll(maskAll), .irqNum(actNum[0]), .fiqNum(actNum[1])
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWe = 1'b0;
  logic [8:0]   busAddr = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic [127:0] srcIn = '0;
  logic         irqReq, fiqReq;
  int           errors = 0;
  int           checks = 0;

  always #5 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .srcIn(srcIn),
    .irqReq(irqReq), .fiqReq(fiqReq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdNow(logic [8:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rdNow(a, d);
  endtask

  task automatic softReset();
    wr(9'h000, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irqReq", 32'(irqReq), 0);
    chk("R1 fiqReq", 32'(fiqReq), 0);
    for (int b = 0; b < 4; b++) begin
      rd(9'h010 + 9'(b), d); chk("R1 mask bank", d, 32'hFFFF_FFFF);
    end
    rd(9'h003, d); chk("R1 threshold", d, 0);
    rd(9'h004, d); chk("R1 irq active", d, 32'h80);
    rd(9'h005, d); chk("R1 fiq active", d, 32'h80);
    rd(9'h001, d); chk("R1 status", d, 1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    softReset();
    wr(9'h019, 32'h0000_00F0);
    rd(9'h011, d); chk("R2 clear alias", d, 32'hFFFF_FF0F);
    wr(9'h015, 32'h0000_0010);
    rd(9'h011, d); chk("R2 set alias", d, 32'hFFFF_FF1F);
    wr(9'h015, 32'h0);
    wr(9'h019, 32'h0);
    rd(9'h011, d); chk("R2 zero writes no effect", d, 32'hFFFF_FF1F);
    rd(9'h010, d); chk("R2 other bank untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    softReset();
    wr(9'h01E, 32'h5);
    rd(9'h01E, d); chk("R3 sw set", d, 32'h5);
    wr(9'h022, 32'h1);
    rd(9'h01E, d); chk("R3 sw clear", d, 32'h4);
    wr(9'h022, 32'h0);
    rd(9'h01E, d); chk("R3 zero clear no effect", d, 32'h4);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    softReset();
    wr(9'h146, 32'hFFFF_FFFF);
    rd(9'h146, d); chk("R4 cfg all ones", d, 32'h1FD);
    wr(9'h146, 32'h0AA);
    rd(9'h146, d); chk("R4 cfg field mapping", d, 32'hA8);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    softReset();
    wr(9'h003, 32'h80);
    wr(9'h105, 32'h28);
    wr(9'h128, 32'h0C);
    wr(9'h129, 32'h0C);
    wr(9'h01C, 32'h20);
    wr(9'h01D, 32'h300);
    repeat (2) @(negedge clk);
    chk("R2 masked lines give no request", 32'(irqReq), 0);
    wr(9'h019, 32'h300);
    wr(9'h018, 32'h20);
    rd(9'h004, d); chk("R5 tie goes to lower number", d, 40);
    chk("R5 irqReq high", 32'(irqReq), 1);
    wr(9'h021, 32'h100);
    wr(9'h002, 32'h1);
    chk("R7 request low after ack", 32'(irqReq), 0);
    rd(9'h004, d); chk("R7 reselect after ack", d, 41);
    wr(9'h021, 32'h200);
    wr(9'h002, 32'h1);
    rd(9'h004, d); chk("R5 larger value last", d, 5);
    wr(9'h020, 32'h20);
    wr(9'h002, 32'h1);
    rd(9'h004, d); chk("R8 spurious when idle", d, 32'h80);
    chk("R8 irqReq low when idle", 32'(irqReq), 0);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    softReset();
    wr(9'h105, 32'h28);
    wr(9'h003, 32'd10);
    wr(9'h01C, 32'h20);
    wr(9'h018, 32'h20);
    repeat (2) @(negedge clk);
    chk("R6 equal to threshold blocked", 32'(irqReq), 0);
    wr(9'h003, 32'd11);
    rd(9'h004, d); chk("R6 below threshold delivered", d, 5);
  endtask

  task automatic t_fiq();
    logic [31:0] d;
    softReset();
    wr(9'h003, 32'h80);
    wr(9'h164, 32'h1);
    srcIn[100] = 1'b1;
    wr(9'h01B, 32'h10);
    rd(9'h005, d); chk("R10 hw line on fast route", d, 100);
    chk("R4 fast route asserts fiqReq", 32'(fiqReq), 1);
    chk("R4 normal output stays low", 32'(irqReq), 0);
    srcIn[100] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 held after line drops", 32'(fiqReq), 1);
    wr(9'h002, 32'h1);
    chk("R7 wrong ack bit ignored", 32'(fiqReq), 1);
    wr(9'h002, 32'h2);
    chk("R7 fast ack drops fiqReq", 32'(fiqReq), 0);
    rd(9'h005, d); chk("R8 fast spurious", d, 32'h80);
  endtask

  task automatic t_softrst();
    logic [31:0] d;
    wr(9'h003, 32'h80);
    wr(9'h100, 32'h0);
    wr(9'h01C, 32'h1);
    wr(9'h018, 32'h1);
    @(negedge clk);
    chk("R9 precondition request", 32'(irqReq), 1);
    wr(9'h000, 32'h1);
    rdNow(9'h001, d); chk("R9 status busy", d, 0);
    chk("R9 request cleared", 32'(irqReq), 0);
    rd(9'h001, d); chk("R9 status done", d, 1);
    rd(9'h010, d); chk("R9 masks restored", d, 32'hFFFF_FFFF);
    rd(9'h003, d); chk("R9 threshold restored", d, 0);
    rd(9'h01C, d); chk("R9 forced bits cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_sw();
    t_cfg();
    t_prio();
    t_thresh();
    t_fiq();
    t_softrst();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule